// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

The block is a watchdog timer behind a small write/read register interface. It holds an 8-bit up-counter and an 8-bit control/status register. A write reaches a register only if the top byte of the write data carries that register's key. The counter steps on ticks from a prescaler. A 3-bit select code chooses one of eight power-of-two divide ratios.

Software arms the timer by writing the control register with the enable bit and a divide code. It then keeps the timer from expiring by reloading the counter with a keyed write. If the counter is allowed to step from 0xFF to 0x00, the block latches a sticky overflow flag and gives one pulse on its overflow output. Neighbouring logic turns that pulse into a reset or an interrupt. The bus width is a parameter, and the key is always taken from the top byte of the write data.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the counter reads 0x00, the control register reads 0x00 (divide code 0, timer disabled, flag clear) and ovf_o is low.
- R2: A write with address 0 is loaded into the counter only when data bits [BUS_W-1:BUS_W-8] equal 0x5A; the low byte becomes the new count. Any other key leaves the counter unchanged.
- R3: A write with address 1 updates the control register only when the top data byte equals 0xA5. Any other key, 0x5A included, leaves it unchanged.
- R4: Reads with address 0 return the count. Reads with address 1 return the control register: bit 7 is enable, bit 6 is the overflow flag, bits 2:0 are the divide code (bit 2 most significant), and bits 5:3 read as zero. No key byte is returned.
- R5: Divide code c makes the counter step once every 32·2^c enabled clock cycles. The first step comes 32·2^c cycles after the write that enables the timer with a cleared prescaler.
- R6: While the enable bit is 0, neither the counter nor the prescaler advances.
- R7: When the counter steps from 0xFF to 0x00, the flag bit is set and ovf_o is high for exactly one cycle, starting at the same clock edge where the count becomes 0x00. From a count of 0x00 the next overflow comes 256·32·2^c cycles later.
- R8: The flag stays set until a keyed control write puts 0 in bit 6. A keyed write with 1 in bit 6 leaves the flag unchanged.
- R9: A keyed control write that changes the divide code restarts the prescaler, so the next step comes one full new period after that write.
- R10: With BUS_W = 32 the key is taken from bits 31:24. A key placed in bits 15:8 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_addr_i | input | 1 | Write target: 0 counter, 1 control register |
| wr_data_i | input | BUS_W | Write data: key in the top byte, value in bits 7:0 |
| rd_addr_i | input | 1 | Read select: 0 counter, 1 control register |
| rd_data_o | output | 8 | Read data of the selected register |
| ovf_o | output | 1 | One-cycle overflow pulse |

## Verification
The assertions assume that wr_en_i, wr_addr_i and wr_data_i are synchronous to clk_i and free of unknown values at each sampling edge. The one-cycle pulse property also relies on the counter step period being much longer than one cycle, which holds for every legal divide code. The stimulus changes every write input only on falling edges and holds a write for exactly one rising edge. Each ratio test first clears the prescaler with two disabled control writes, so every measured interval starts from a known prescaler count.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] CNT_KEY  = 8'h5A;
  localparam logic [7:0] CSR_KEY  = 8'hA5;
  localparam int         SEL_W    = 3;
  localparam int         EN_BIT   = 7;
  localparam int         FLAG_BIT = 6;

  typedef struct packed {
    logic             en;
    logic             flag;
    logic [SEL_W-1:0] sel;
  } csr_t;
endpackage

// File: rtl/wdt_wr_decode.sv
module wdt_wr_decode #(
  parameter int BUS_W = 16
) (
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [BUS_W-1:0] wr_data_i,
  output logic             cnt_we_o,
  output logic             csr_we_o,
  output logic [7:0]       wdata_o
);
  import wdt_pkg::*;

  localparam int KEY_LSB = BUS_W - 8;

  logic [7:0] key;

  assign key      = wr_data_i[KEY_LSB +: 8];
  assign wdata_o  = wr_data_i[7:0];
  assign cnt_we_o = wr_en_i && !wr_addr_i && (key == CNT_KEY);
  assign csr_we_o = wr_en_i &&  wr_addr_i && (key == CSR_KEY);
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int BASE_LOG2 = 5,
  parameter int SEL_W     = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int PRE_W = BASE_LOG2 + (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] term;

  // terminal count = 2^(BASE_LOG2+sel) - 1
  assign term   = PRE_W'((1 << (BASE_LOG2 + int'(sel_i))) - 1);
  assign tick_o = en_i && (pre_q == term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (clr_i)  pre_q <= '0;
    else if (en_i)   pre_q <= tick_o ? '0 : pre_q + 1'b1;
  end

  assert_pre_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= term);

  assert_pre_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(pre_q));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_evt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;

  // a reload in the wrap cycle wins and suppresses the overflow
  assign ovf_evt_o = tick_i && !ld_i && (&cnt_q);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_o <= 1'b0;
    end else begin
      ovf_o <= ovf_evt_o;
      if (ld_i)        cnt_q <= ld_val_i;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_ovf_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> !ovf_o);

  assert_ovf_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (cnt_q == '0));

  assert_cnt_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_csr.sv
module wdt_csr
  import wdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  input  logic       ovf_evt_i,
  output csr_t       csr_o,
  output logic       sel_chg_o
);
  csr_t csr_q;

  assign csr_o     = csr_q;
  assign sel_chg_o = we_i && (wdata_i[SEL_W-1:0] != csr_q.sel);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csr_q <= '0;
    end else begin
      if (we_i) begin
        csr_q.en  <= wdata_i[EN_BIT];
        csr_q.sel <= wdata_i[SEL_W-1:0];
      end
      // software may only clear the flag; a new overflow wins
      csr_q.flag <= ovf_evt_i | (we_i ? (csr_q.flag & wdata_i[FLAG_BIT]) : csr_q.flag);
    end
  end

  assert_flag_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt_i |=> csr_q.flag);

  assert_flag_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && csr_q.flag) |=> csr_q.flag);

  assert_csr_ignore_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(csr_q.en) && $stable(csr_q.sel)));
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int BUS_W     = 16,
  parameter int BASE_LOG2 = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [BUS_W-1:0] wr_data_i,
  input  logic             rd_addr_i,
  output logic [7:0]       rd_data_o,
  output logic             ovf_o
);
  import wdt_pkg::*;

  logic       cnt_we, csr_we, sel_chg, tick, ovf_evt;
  logic [7:0] wdata, cnt;
  csr_t       csr;

  wdt_wr_decode #(.BUS_W(BUS_W)) u_dec (
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .cnt_we_o (cnt_we),
    .csr_we_o (csr_we),
    .wdata_o  (wdata)
  );

  wdt_csr u_csr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (csr_we),
    .wdata_i  (wdata),
    .ovf_evt_i(ovf_evt),
    .csr_o    (csr),
    .sel_chg_o(sel_chg)
  );

  wdt_prescaler #(.BASE_LOG2(BASE_LOG2), .SEL_W(SEL_W)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (csr.en),
    .clr_i (sel_chg),
    .sel_i (csr.sel),
    .tick_o(tick)
  );

  wdt_counter #(.CNT_W(8)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (cnt_we),
    .ld_val_i (wdata),
    .tick_i   (tick),
    .cnt_o    (cnt),
    .ovf_evt_o(ovf_evt),
    .ovf_o    (ovf_o)
  );

  assign rd_data_o = rd_addr_i ? {csr.en, csr.flag, 3'b000, csr.sel} : cnt;

  assert_tick_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csr.en && !cnt_we) |=> $stable(cnt));
endmodule

// File: tb/keyed_wdt_test.sv
`timescale 1ns/1ps
module keyed_wdt_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
  logic [15:0] wr_data = '0;
  logic [7:0]  rd_data;
  logic        ovf;
  logic        wr_en32 = 1'b0, wr_addr32 = 1'b0, rd_addr32 = 1'b0;
  logic [31:0] wr_data32 = '0;
  logic [7:0]  rd_data32;
  logic        ovf32;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  keyed_wdt #(.BUS_W(16)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .ovf_o(ovf));

  keyed_wdt #(.BUS_W(32)) uut_w32 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en32), .wr_addr_i(wr_addr32),
    .wr_data_i(wr_data32), .rd_addr_i(rd_addr32), .rd_data_o(rd_data32), .ovf_o(ovf32));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wr32(input logic a, input logic [31:0] d);
    @(negedge clk); wr_en32 = 1'b1; wr_addr32 = a; wr_data32 = d;
    @(negedge clk); wr_en32 = 1'b0; wr_data32 = '0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    rd_addr = a; #0.5; v = rd_data;
  endtask

  // disabled control writes that also restart the prescaler
  task automatic quiesce();
    wr(1'b1, 16'hA501);
    wr(1'b1, 16'hA500);
  endtask

  // count rising edges until ovf_o is seen high
  task automatic wait_ovf(output int n);
    n = 0;
    do begin
      @(posedge clk); #1; n++;
    end while (!ovf && n < 20000);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(1'b0, v); chk("R1 counter", v, 8'h00);
    rd(1'b1, v); chk("R1 control", v, 8'h00);
    chk("R1 ovf_o", ovf, 0);
  endtask

  task automatic t_keys();
    logic [7:0] v;
    wr(1'b0, 16'h5A3C); rd(1'b0, v); chk("R2 keyed load", v, 8'h3C);
    wr(1'b0, 16'h5B77); rd(1'b0, v); chk("R2 bad key", v, 8'h3C);
    wr(1'b0, 16'hA511); rd(1'b0, v); chk("R2 control key on counter", v, 8'h3C);
    wr(1'b1, 16'h5A85); rd(1'b1, v); chk("R3 counter key on control", v, 8'h00);
    wr(1'b1, 16'h1285); rd(1'b1, v); chk("R3 bad key", v, 8'h00);
    wr(1'b1, 16'hA5FD); rd(1'b1, v); chk("R4 readback layout", v, 8'h85);
    wr(1'b1, 16'hA500); rd(1'b1, v); chk("R3 keyed clear", v, 8'h00);
    rd(1'b0, v); chk("R4 counter readback", v, 8'h3C);
  endtask

  task automatic t_gate();
    logic [7:0] v;
    quiesce();
    wr(1'b0, 16'h5A10);
    repeat (200) @(posedge clk);
    #1; rd(1'b0, v); chk("R6 disabled hold", v, 8'h10);
    wr(1'b1, 16'hA580);
    repeat (160) @(posedge clk);
    #1; rd(1'b0, v); chk("R5 five steps at /32", v, 8'h15);
    wr(1'b1, 16'hA500);
    repeat (300) @(posedge clk);
    #1; rd(1'b0, v); chk("R6 hold after disable", v, 8'h15);
  endtask

  task automatic t_ratio(input int c);
    int n;
    logic [7:0] v;
    quiesce();
    wr(1'b0, 16'h5AFF);
    wr(1'b1, 16'hA580 | 16'(c));
    wait_ovf(n);
    chk($sformatf("R5 period code %0d", c), n, 32 << c);
    rd(1'b0, v); chk("R7 count wrapped", v, 8'h00);
    rd(1'b1, v); chk("R7 flag set", v[6], 1);
    @(posedge clk); #1; chk("R7 pulse one cycle", ovf, 0);
  endtask

  task automatic t_full();
    int n;
    quiesce();
    wr(1'b0, 16'h5A00);
    wr(1'b1, 16'hA580);
    wait_ovf(n);
    chk("R7 full period", n, 256 * 32);
  endtask

  task automatic t_flag();
    logic [7:0] v;
    repeat (50) @(posedge clk);
    #1; rd(1'b1, v); chk("R8 flag sticky", v, 8'hC0);
    wr(1'b1, 16'hA5C0); rd(1'b1, v); chk("R8 write one keeps flag", v, 8'hC0);
    wr(1'b1, 16'h33C0 & 16'hFF80); rd(1'b1, v); chk("R8 unkeyed clear ignored", v, 8'hC0);
    wr(1'b1, 16'hA580); rd(1'b1, v); chk("R8 write zero clears", v, 8'h80);
    quiesce();
  endtask

  task automatic t_sel_change();
    int n;
    quiesce();
    wr(1'b0, 16'h5AFF);
    wr(1'b1, 16'hA580);
    repeat (20) @(posedge clk);
    wr(1'b1, 16'hA581);
    wait_ovf(n);
    chk("R9 restart on code change", n, 64);
    quiesce();
  endtask

  task automatic t_w32();
    logic [7:0] v;
    wr32(1'b0, 32'h0000_5A42);
    rd_addr32 = 1'b0; #0.5; v = rd_data32; chk("R10 low key ignored", v, 8'h00);
    wr32(1'b0, 32'h5A00_0042);
    #0.5; v = rd_data32; chk("R10 top key load", v, 8'h42);
    wr32(1'b1, 32'hA500_0003);
    rd_addr32 = 1'b1; #0.5; v = rd_data32; chk("R10 top key control", v, 8'h03);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_keys();
    t_gate();
    t_ratio(0);
    t_ratio(3);
    t_ratio(7);
    t_full();
    t_flag();
    t_sel_change();
    t_w32();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule